// File: doc/BRIEF.md
# ADC Result Window Comparator

This block watches the conversion results produced for one chosen sample slot and compares each newly loaded result against a programmed 12-bit threshold. Depending on a condition bit, it counts results that fall strictly below the threshold or results that are at or above it. Once the count of consecutive qualifying results reaches the programmed match count plus one, a sticky match flag is set, and an interrupt request follows if the interrupt enable is on.

Eight result sources feed the block, as two converters with four slots each. Every source supplies a load strobe and a 12-bit value. A 3-bit select picks which source is monitored. A live compare output bit shows the side of the threshold on which the last compared result fell. Software clears the match flag by writing 1 to it.

Top module: `adc_window_cmp`

## Requirements
- R1: After reset the match flag, the interrupt request and the compare output bit are all 0.
- R2: A result is compared only when the compare enable is 1 and the load strobe of the selected source is high. Strobes from other sources, or any strobe while compare is disabled, change neither the flag, the compare output nor the match counter.
- R3: Select code s in 0..3 picks converter 0, slot s. Codes 4..7 pick converter 1, slot s-4. The source index is the code, where sources 0..3 are converter 0 and sources 4..7 are converter 1.
- R4: With the condition bit at 0, a result qualifies when it is strictly below the threshold. With the condition bit at 1, a result qualifies when it is greater than or equal to the threshold.
- R5: The compare output bit updates one cycle after each compared load. It reads 1 when that result was greater than or equal to the threshold and 0 otherwise, whatever the condition bit is.
- R6: The match flag is set one cycle after the qualifying compare that brings the consecutive-match count to the match count plus 1. The match count is 4 bits, so the count can run from 1 to 16.
- R7: A compared result that does not qualify resets the match counter to 0.
- R8: The counter restarts from 0 in the cycle the flag is set.
- R9: Setting the compare enable to 0 clears the match counter.
- R10: A clear pulse removes the flag on the next cycle. If a clear pulse and a flag-setting compare occur in the same cycle, the flag stays set.
- R11: The interrupt request is 1 exactly while the flag is set and the interrupt enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_strobe | input | 8 | Per-source result load strobes (0..3 converter 0, 4..7 converter 1) |
| ld_data | input | 96 | Per-source 12-bit results, source i at bits 12i+11:12i |
| cmp_en | input | 1 | Compare enable |
| irq_en | input | 1 | Interrupt enable |
| cond_ge | input | 1 | Condition: 0 counts below threshold, 1 counts at or above it |
| src_sel | input | 3 | Monitored source select |
| match_cnt | input | 4 | Required matches minus one |
| threshold | input | 12 | Compare threshold |
| flag_clr | input | 1 | Write-one-to-clear pulse for the match flag |
| cmp_out | output | 1 | Side of the threshold of the last compared result |
| match_flag | output | 1 | Sticky match flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: eight sources, 12-bit data and a 4-bit match count. With these values the widest count of sixteen consecutive matches can be reached in a short run, and every select code is driven. Threshold edge values (equal, one below, zero and full scale) test the strict and non-strict sides of both conditions.

// File: rtl/adc_window_cmp_pkg.sv
package adc_window_cmp_pkg;
  parameter int unsigned DATA_W   = 12;
  parameter int unsigned N_SRC    = 8;
  parameter int unsigned MCNT_W   = 4;
  localparam int unsigned SEL_W   = $clog2(N_SRC);
  localparam int unsigned CTR_W   = MCNT_W + 1;

  typedef enum logic {
    COND_BELOW = 1'b0,
    COND_GE    = 1'b1
  } cond_e;

  typedef struct packed {
    logic              hit;
    logic [DATA_W-1:0] value;
  } sample_t;
endpackage

// File: rtl/adc_src_mux.sv
module adc_src_mux
  import adc_window_cmp_pkg::*;
#(
  parameter int unsigned NS = N_SRC,
  parameter int unsigned DW = DATA_W,
  localparam int unsigned SW = $clog2(NS)
) (
  input  logic [NS-1:0]    strobe,
  input  logic [NS*DW-1:0] data,
  input  logic [SW-1:0]    sel,
  output sample_t          picked
);
  logic [DW-1:0] data_arr [NS];

  for (genvar gi = 0; gi < NS; gi++) begin : g_unpack
    assign data_arr[gi] = data[gi*DW +: DW];
  end

  always_comb begin
    picked.hit   = strobe[sel];
    picked.value = data_arr[sel];
  end
endmodule

// File: rtl/adc_match_ctr.sv
module adc_match_ctr
  import adc_window_cmp_pkg::*;
#(
  parameter int unsigned MW = MCNT_W,
  localparam int unsigned CW = MW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          evaluate,
  input  logic          qualifies,
  input  logic [MW-1:0] target,
  output logic          reached
);
  logic [CW-1:0] ctr_q, ctr_d;
  logic [CW-1:0] ctr_inc;
  logic [CW-1:0] goal;

  assign ctr_inc = ctr_q + CW'(1);
  assign goal    = {1'b0, target} + CW'(1);
  assign reached = enable && evaluate && qualifies && (ctr_inc == goal);

  always_comb begin
    ctr_d = ctr_q;
    if (!enable)
      ctr_d = '0;
    else if (evaluate) begin
      if (!qualifies)   ctr_d = '0;
      else if (reached) ctr_d = '0;
      else              ctr_d = ctr_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctr_q <= '0;
    else        ctr_q <= ctr_d;
  end

  AST_CTR_BELOW_GOAL: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_q < goal || $changed(target)) else $error("counter past goal"); // R6
  AST_CTR_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ctr_q == '0) else $error("counter not cleared"); // R9
  AST_CTR_FAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (evaluate && !qualifies) |=> ctr_q == '0) else $error("counter not reset"); // R7
endmodule

// File: rtl/adc_flag_ctrl.sv
module adc_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set_evt)      flag_d = 1'b1;
    else if (clr_req) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
  assign irq  = flag_q & irq_en;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag) else $error("flag lost on set"); // R10
  AST_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_evt) |=> !flag) else $error("flag not cleared"); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag) else $error("flag dropped"); // R6
endmodule

// File: rtl/adc_window_cmp.sv
module adc_window_cmp
  import adc_window_cmp_pkg::*;
#(
  parameter int unsigned NS = N_SRC,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned MW = MCNT_W,
  localparam int unsigned SW = $clog2(NS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NS-1:0]    ld_strobe,
  input  logic [NS*DW-1:0] ld_data,
  input  logic             cmp_en,
  input  logic             irq_en,
  input  logic             cond_ge,
  input  logic [SW-1:0]    src_sel,
  input  logic [MW-1:0]    match_cnt,
  input  logic [DW-1:0]    threshold,
  input  logic             flag_clr,
  output logic             cmp_out,
  output logic             match_flag,
  output logic             irq
);
  sample_t picked;
  logic    evaluate;
  logic    at_or_above;
  logic    qualifies;
  logic    reached;
  logic    cmp_q, cmp_d;
  cond_e   cond;

  adc_src_mux #(.NS(NS), .DW(DW)) u_mux (
    .strobe (ld_strobe),
    .data   (ld_data),
    .sel    (src_sel),
    .picked (picked)
  );

  assign cond        = cond_e'(cond_ge);
  assign evaluate    = cmp_en & picked.hit;
  assign at_or_above = picked.value >= threshold;
  assign qualifies   = (cond == COND_GE) ? at_or_above : !at_or_above;

  adc_match_ctr #(.MW(MW)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (cmp_en),
    .evaluate  (evaluate),
    .qualifies (qualifies),
    .target    (match_cnt),
    .reached   (reached)
  );

  adc_flag_ctrl u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (reached),
    .clr_req (flag_clr),
    .irq_en  (irq_en),
    .flag    (match_flag),
    .irq     (irq)
  );

  always_comb begin
    cmp_d = cmp_q;
    if (evaluate) cmp_d = at_or_above;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= 1'b0;
    else        cmp_q <= cmp_d;
  end

  assign cmp_out = cmp_q;

  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !evaluate |=> $stable(cmp_out)) else $error("cmp_out moved"); // R2
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (match_flag && irq_en)) else $error("irq mismatch"); // R11
  AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_en && !match_flag) |=> !match_flag) else $error("set while off"); // R2
endmodule

// File: tb/adc_window_cmp_test.sv
`timescale 1ns/1ps
module adc_window_cmp_test;
  localparam int NS = 8;
  localparam int DW = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NS-1:0]   ld_strobe = '0;
  logic [NS*DW-1:0] ld_data = '0;
  logic            cmp_en = 1'b0, irq_en = 1'b0, cond_ge = 1'b0, flag_clr = 1'b0;
  logic [2:0]      src_sel = '0;
  logic [3:0]      match_cnt = '0;
  logic [11:0]     threshold = '0;
  logic            cmp_out, match_flag, irq;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  adc_window_cmp uut (
    .clk, .rst_n, .ld_strobe, .ld_data, .cmp_en, .irq_en, .cond_ge,
    .src_sel, .match_cnt, .threshold, .flag_clr, .cmp_out, .match_flag, .irq
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // one compared load on source s, value v; outputs sampled after the edge
  task automatic load(input int s, input logic [11:0] v);
    @(negedge clk);
    ld_data = '0;
    ld_data[s*DW +: DW] = v;
    ld_strobe = '0;
    ld_strobe[s] = 1'b1;
    @(negedge clk);
    ld_strobe = '0;
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  // vector: cond, threshold, value, expected cmp_out, expected flag (match_cnt=0)
  typedef struct packed {
    logic        cnd;
    logic [11:0] thr;
    logic [11:0] val;
    logic        e_cmp;
    logic        e_flag;
  } vec_t;
  localparam vec_t VECS [8] = '{
    '{1'b0, 12'd100, 12'd99,   1'b0, 1'b1},
    '{1'b0, 12'd100, 12'd100,  1'b1, 1'b0},
    '{1'b1, 12'd100, 12'd100,  1'b1, 1'b1},
    '{1'b1, 12'd100, 12'd99,   1'b0, 1'b0},
    '{1'b0, 12'd0,   12'd0,    1'b1, 1'b0},
    '{1'b1, 12'd0,   12'd0,    1'b1, 1'b1},
    '{1'b0, 12'hFFF, 12'hFFE,  1'b0, 1'b1},
    '{1'b1, 12'hFFF, 12'hFFF,  1'b1, 1'b1}
  };

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 flag", match_flag, 1'b0);
    check("R1 irq", irq, 1'b0);
    check("R1 cmp", cmp_out, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R5 vector table, source 0, match count 0
    cmp_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      cond_ge = VECS[i].cnd;
      threshold = VECS[i].thr;
      load(0, VECS[i].val);
      check("R5 cmp_out", cmp_out, VECS[i].e_cmp);
      check("R4 flag", match_flag, VECS[i].e_flag);
      clear_flag();
      check("R10 cleared", match_flag, 1'b0);
    end

    // R3 every select code sees only its own source
    cond_ge = 1'b1; threshold = 12'd500;
    for (int s = 0; s < 8; s++) begin
      src_sel = 3'(s);
      load((s + 1) % 8, 12'd900);
      check("R3 other source ignored", match_flag, 1'b0);
      load(s, 12'd900);
      check("R3 selected source", match_flag, 1'b1);
      clear_flag();
    end
    src_sel = 3'd0;

    // R2 disabled compare ignores strobes
    cmp_en = 1'b0;
    load(0, 12'd900);
    check("R2 disabled flag", match_flag, 1'b0);
    cmp_en = 1'b1;
    load(0, 12'd10);
    check("R2 cmp after", cmp_out, 1'b0);

    // R6 match count 2: three in a row
    match_cnt = 4'd2;
    load(0, 12'd600); load(0, 12'd700);
    check("R6 two not enough", match_flag, 1'b0);
    load(0, 12'd800);
    check("R6 third sets", match_flag, 1'b1);
    clear_flag();
    // R8 counter restarted: two more does not set
    load(0, 12'd600); load(0, 12'd600);
    check("R8 restart", match_flag, 1'b0);
    load(0, 12'd600);
    check("R8 third after restart", match_flag, 1'b1);
    clear_flag();

    // R7 failing result resets count
    load(0, 12'd600); load(0, 12'd600); load(0, 12'd10);
    load(0, 12'd600); load(0, 12'd600);
    check("R7 reset by miss", match_flag, 1'b0);
    load(0, 12'd600);
    check("R7 count resumes", match_flag, 1'b1);
    clear_flag();

    // R9 disabling clears count
    load(0, 12'd600); load(0, 12'd600);
    @(negedge clk); cmp_en = 1'b0;
    @(negedge clk); cmp_en = 1'b1;
    load(0, 12'd600); load(0, 12'd600);
    check("R9 cleared by disable", match_flag, 1'b0);
    load(0, 12'd600);
    check("R9 third sets", match_flag, 1'b1);
    clear_flag();

    // R6 max count 15 -> sixteen loads
    match_cnt = 4'd15;
    for (int k = 0; k < 15; k++) load(0, 12'd600);
    check("R6 fifteen not enough", match_flag, 1'b0);
    load(0, 12'd600);
    check("R6 sixteenth sets", match_flag, 1'b1);

    // R11 irq gating
    irq_en = 1'b0; #1;
    check("R11 irq masked", irq, 1'b0);
    irq_en = 1'b1; #1;
    check("R11 irq raised", irq, 1'b1);
    clear_flag();
    check("R11 irq drops", irq, 1'b0);

    // R10 clear and set in same cycle: set wins
    match_cnt = 4'd0;
    @(negedge clk);
    ld_data = '0; ld_data[11:0] = 12'd600; ld_strobe = 8'h01; flag_clr = 1'b1;
    @(negedge clk);
    ld_strobe = '0; flag_clr = 1'b0;
    check("R10 set wins", match_flag, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule